// File: doc/BRIEF.md
# Bus-mapped control registers with streaming port bank

This block is a Wishbone slave that gives a host a small control surface over a processing core. One part is a register file. Mode registers are written by the host and drive the core's configuration lines. Status registers show live values from the core. An event register latches single-cycle pulses from the core until the host clears them.

The other part is a bank of 2^PORT_BITS streaming ports. A bus write to a port address places a word in that port's outbound queue, which the core drains with a valid/ready handshake. The core fills each port's inbound queue through its own valid/ready handshake, and a bus read from the port address takes the oldest word. A host script can therefore feed test vectors to a core that expects queued input and collect its results one word at a time.

The bus address carries word offsets only: `wb_adr_i` holds byte-address bits [AW-1:2]. Every access is a single classic cycle, answered by a one-clock acknowledge.

Top module: `ctl_regport`

## Requirements
- R1: Byte address bit 7 low selects the register file. With the default parameters the mode registers sit at 0x00 and 0x04, the status registers at 0x08 and 0x0C, the event register at 0x10 and the underflow register at 0x14. Bit 7 high selects port p at 0x80 + 4*p. A read from any other register-file address returns zero and is acknowledged.
- R2: A mode register returns the last value written to it, resets to zero, and drives its word of `mode_o` continuously.
- R3: A status register reads the present value of its word of `status_i`. A write to it is acknowledged and changes nothing.
- R4: A pulse on bit k of `event_i` sets bit k of the event register, and the bit stays set. Writing 1 to bit k clears it, and writing 0 leaves it as it is. When a pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: `wb_ack_o` rises on the clock edge after the first edge at which `wb_cyc_i` and `wb_stb_i` are both high. It stays high for exactly one clock per access.
- R6: A write to port p appends the word to that port's outbound queue, which holds FIFO_DEPTH words. `out_valid_o[p]` is high while the queue holds data, and `out_data_o` word p shows the oldest entry. A clock edge with valid and `out_ready_i[p]` both high removes that entry, so words arrive in the order they were written.
- R7: A write to a port whose outbound queue is full is not acknowledged and not stored. The write completes on the edge after the first edge at which the queue is no longer full.
- R8: `in_ready_o[p]` is high while port p's inbound queue, which holds FIFO_DEPTH words, is not full. A word is taken on an edge with `in_valid_i[p]` and `in_ready_o[p]` both high. A read from port p returns the oldest word and removes it.
- R9: A read from a port whose inbound queue is empty returns zero, is acknowledged, and sets bit p of the underflow register. The underflow register clears bits written as 1, and a new underflow wins over a clear in the same cycle.
- R10: While `rst_ni` is low, `wb_ack_o`, `mode_o` and `out_valid_o` are zero and `in_ready_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | AW-2 | Word address (byte bits AW-1:2) |
| wb_dat_i | input | DW | Write data |
| wb_dat_o | output | DW | Read data, zero outside read acknowledges |
| wb_ack_o | output | 1 | Acknowledge |
| mode_o | output | N_MODE*DW | Mode register contents, register i in word i |
| status_i | input | N_STAT*DW | Live status words |
| event_i | input | DW | Event pulses latched by the event register |
| out_valid_o | output | 2^PORT_BITS | Outbound word available, one bit per port |
| out_data_o | output | 2^PORT_BITS*DW | Oldest outbound word, per port |
| out_ready_i | input | 2^PORT_BITS | Core accepts an outbound word |
| in_valid_i | input | 2^PORT_BITS | Core offers an inbound word |
| in_data_i | input | 2^PORT_BITS*DW | Inbound words, per port |
| in_ready_o | output | 2^PORT_BITS | Inbound queue has room |

## Verification
The directed part covers each register kind in turn. It writes and reads back patterns in the mode registers. It writes to status registers while their inputs change, to show the writes have no effect. It raises an event in the same cycle as its clear, which separates a set-wins event register from a clear-wins one. On the ports, a queue is filled past its depth from the bus side with the consumer stalled, which shows whether the acknowledge is held or the word is dropped. An inbound queue is filled while the core keeps offering data, then read once past empty, which shows the underflow path and the zero return. A random phase then mixes port traffic on all ports with random valid and ready patterns, register accesses and sparse event pulses. This exposes ordering errors, lost words and clashes between a pop and a push on the same edge.

// File: rtl/ctl_regport_pkg.sv
package ctl_regport_pkg;

  typedef enum logic [2:0] {
    RG_MODE,
    RG_STAT,
    RG_EVT,
    RG_UFL,
    RG_NONE
  } region_e;

  // Register-file map: modes, then status words, then event word, then underflow word
  function automatic region_e reg_region(input int unsigned idx,
                                         input int unsigned n_mode,
                                         input int unsigned n_stat);
    if (idx < n_mode) return RG_MODE;
    if (idx < n_mode + n_stat) return RG_STAT;
    if (idx == n_mode + n_stat) return RG_EVT;
    if (idx == n_mode + n_stat + 1) return RG_UFL;
    return RG_NONE;
  endfunction

endpackage

// File: rtl/ctl_regport_fifo.sv
module ctl_regport_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/ctl_regport_regs.sv
module ctl_regport_regs
  import ctl_regport_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IW     = 5,
  parameter int N_MODE = 2,
  parameter int N_STAT = 2,
  parameter int NPORT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [N_STAT*DW-1:0] status_i,
  input  logic [DW-1:0]     event_i,
  input  logic [NPORT-1:0]  ufl_set_i,
  output logic [DW-1:0]     rdata_o,
  output logic [N_MODE*DW-1:0] mode_o
);
  region_e       region;
  logic [DW-1:0] mode_q [N_MODE];
  logic [DW-1:0] evt_q;
  logic [NPORT-1:0] ufl_q;
  logic [DW-1:0] evt_clr;
  logic [NPORT-1:0] ufl_clr;

  assign region  = reg_region(32'(idx_i), N_MODE, N_STAT);
  assign evt_clr = (wr_i && region == RG_EVT) ? wdata_i : '0;
  assign ufl_clr = (wr_i && region == RG_UFL) ? wdata_i[NPORT-1:0] : '0;

  for (genvar i = 0; i < N_MODE; i++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q[i] <= '0;
      else if (wr_i && idx_i == IW'(i)) mode_q[i] <= wdata_i;
    end
    assign mode_o[i*DW +: DW] = mode_q[i];
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      ufl_q <= '0;
    end else begin
      evt_q <= (evt_q & ~evt_clr) | event_i;
      ufl_q <= (ufl_q & ~ufl_clr) | ufl_set_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (region)
      RG_MODE: for (int i = 0; i < N_MODE; i++)
                 if (idx_i == IW'(i)) rdata_o = mode_q[i];
      RG_STAT: for (int i = 0; i < N_STAT; i++)
                 if (idx_i == IW'(N_MODE + i)) rdata_o = status_i[i*DW +: DW];
      RG_EVT:  rdata_o = evt_q;
      RG_UFL:  rdata_o = DW'(ufl_q);
      default: rdata_o = '0;
    endcase
  end

  p_event_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((evt_q & $past(event_i)) == $past(event_i)));
  p_event_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && region == RG_EVT) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  p_mode_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && region == RG_MODE) |=> $stable(mode_o));
  p_ufl_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ufl_set_i != '0) |=> ((ufl_q & $past(ufl_set_i)) == $past(ufl_set_i)));

endmodule

// File: rtl/ctl_regport_ports.sv
module ctl_regport_ports #(
  parameter int DW        = 32,
  parameter int PORT_BITS = 2,
  parameter int DEPTH     = 4,
  localparam int NPORT    = 1 << PORT_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic                 pop_i,
  input  logic [PORT_BITS-1:0] sel_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NPORT-1:0]     out_full_o,
  output logic [NPORT-1:0]     ufl_set_o,
  output logic [NPORT-1:0]     out_valid_o,
  output logic [NPORT*DW-1:0]  out_data_o,
  input  logic [NPORT-1:0]     out_ready_i,
  input  logic [NPORT-1:0]     in_valid_i,
  input  logic [NPORT*DW-1:0]  in_data_i,
  output logic [NPORT-1:0]     in_ready_o
);
  logic [DW-1:0]    in_head [NPORT];
  logic [NPORT-1:0] in_empty, in_full, out_empty;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit;
    assign hit = (sel_i == PORT_BITS'(p));

    ctl_regport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_i && hit),
      .wdata_i (wdata_i),
      .pop_i   (out_valid_o[p] && out_ready_i[p]),
      .head_o  (out_data_o[p*DW +: DW]),
      .full_o  (out_full_o[p]),
      .empty_o (out_empty[p])
    );
    assign out_valid_o[p] = !out_empty[p];

    ctl_regport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[p] && !in_full[p]),
      .wdata_i (in_data_i[p*DW +: DW]),
      .pop_i   (pop_i && hit && !in_empty[p]),
      .head_o  (in_head[p]),
      .full_o  (in_full[p]),
      .empty_o (in_empty[p])
    );
    assign in_ready_o[p] = !in_full[p];
    assign ufl_set_o[p]  = pop_i && hit && in_empty[p];
  end

  assign rdata_o = in_empty[sel_i] ? '0 : in_head[sel_i];

  p_ufl_one_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ufl_set_o));

endmodule

// File: rtl/ctl_regport.sv
module ctl_regport #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int N_MODE    = 2,
  parameter int N_STAT    = 2,
  parameter int PORT_BITS = 2,
  parameter int DEPTH     = 4,
  localparam int NPORT    = 1 << PORT_BITS,
  localparam int IW       = AW - 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wb_cyc_i,
  input  logic                 wb_stb_i,
  input  logic                 wb_we_i,
  input  logic [AW-1:2]        wb_adr_i,
  input  logic [DW-1:0]        wb_dat_i,
  output logic [DW-1:0]        wb_dat_o,
  output logic                 wb_ack_o,
  output logic [N_MODE*DW-1:0] mode_o,
  input  logic [N_STAT*DW-1:0] status_i,
  input  logic [DW-1:0]        event_i,
  output logic [NPORT-1:0]     out_valid_o,
  output logic [NPORT*DW-1:0]  out_data_o,
  input  logic [NPORT-1:0]     out_ready_i,
  input  logic [NPORT-1:0]     in_valid_i,
  input  logic [NPORT*DW-1:0]  in_data_i,
  output logic [NPORT-1:0]     in_ready_o
);
  logic                 req, is_port, stall, go, wr_en, rd_en;
  logic [PORT_BITS-1:0] sel;
  logic [IW-1:0]        idx;
  logic [DW-1:0]        reg_rdata, port_rdata;
  logic [NPORT-1:0]     out_full, ufl_set;
  logic                 ack_q;
  logic [DW-1:0]        dat_q;

  assign req     = wb_cyc_i && wb_stb_i;
  assign is_port = wb_adr_i[AW-1];
  assign idx     = wb_adr_i[AW-2:2];
  assign sel     = wb_adr_i[PORT_BITS+1:2];
  assign stall   = wb_we_i && is_port && out_full[sel];
  assign go      = req && !ack_q && !stall;
  assign wr_en   = go && wb_we_i;
  assign rd_en   = go && !wb_we_i;

  ctl_regport_regs #(
    .DW(DW), .IW(IW), .N_MODE(N_MODE), .N_STAT(N_STAT), .NPORT(NPORT)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en && !is_port),
    .idx_i     (idx),
    .wdata_i   (wb_dat_i),
    .status_i  (status_i),
    .event_i   (event_i),
    .ufl_set_i (ufl_set),
    .rdata_o   (reg_rdata),
    .mode_o    (mode_o)
  );

  ctl_regport_ports #(.DW(DW), .PORT_BITS(PORT_BITS), .DEPTH(DEPTH)) u_ports (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_en && is_port),
    .pop_i       (rd_en && is_port),
    .sel_i       (sel),
    .wdata_i     (wb_dat_i),
    .rdata_o     (port_rdata),
    .out_full_o  (out_full),
    .ufl_set_o   (ufl_set),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= go;
      dat_q <= rd_en ? (is_port ? port_rdata : reg_rdata) : '0;
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;

  p_ack_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);
  p_ack_after_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));
  p_full_holds_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && wb_we_i && is_port && out_full[sel]) |=> !wb_ack_o);
  p_dat_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_ack_o |-> (wb_dat_o == '0));

endmodule

// File: tb/ctl_regport_tb.sv
module ctl_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, N_MODE = 2, N_STAT = 2, NPORT = 4, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic cyc = 0, stb = 0, we = 0;
  logic [7:2] adr = '0;
  logic [DW-1:0] wdat = '0, wb_dat_o;
  logic wb_ack_o;
  logic [N_MODE*DW-1:0] mode_o;
  logic [N_STAT*DW-1:0] status_i = '0;
  logic [DW-1:0] event_i = '0;
  logic [NPORT-1:0] out_valid_o, out_ready_i = '0, in_valid_i = '0, in_ready_o;
  logic [NPORT*DW-1:0] out_data_o, in_data_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_regport u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .mode_o(mode_o), .status_i(status_i), .event_i(event_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit rnd = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model
  logic [DW-1:0] oq [NPORT][$];
  logic [DW-1:0] iq [NPORT][$];
  logic [DW-1:0] mode_m [N_MODE];
  logic [DW-1:0] evt_m;
  logic [NPORT-1:0] ufl_m;
  bit exp_ack;
  logic [DW-1:0] exp_dat;
  string dat_tag = "R1", ack_tag = "R5";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NPORT; q++) begin oq[q].delete(); iq[q].delete(); end
      for (int i = 0; i < N_MODE; i++) mode_m[i] = '0;
      evt_m = '0; ufl_m = '0; exp_ack = 0; exp_dat = '0;
    end else begin
      automatic bit req = cyc && stb;
      automatic bit isp = adr[7];
      automatic int p = int'(adr[3:2]);
      automatic int idx = int'(adr[6:2]);
      automatic bit full = isp && we && (oq[p].size() == DEPTH);
      automatic bit go = req && !exp_ack && !full;
      automatic bit drain [NPORT];
      automatic bit acc [NPORT];
      automatic int isz = iq[p].size();
      automatic logic [DW-1:0] rdata = '0;
      automatic logic [DW-1:0] clr_e = '0;
      automatic logic [NPORT-1:0] clr_u = '0, uset = '0;
      automatic string tag = "R1";
      for (int q = 0; q < NPORT; q++) begin
        drain[q] = oq[q].size() > 0 && out_ready_i[q];
        acc[q] = in_valid_i[q] && iq[q].size() < DEPTH;
      end
      if (isp) begin
        if (isz > 0) begin rdata = iq[p][0]; tag = "R8"; end
        else begin tag = "R9"; if (go && !we) uset[p] = 1'b1; end
      end else if (idx < N_MODE) begin rdata = mode_m[idx]; tag = "R2"; end
      else if (idx < N_MODE + N_STAT) begin rdata = status_i[(idx-N_MODE)*DW +: DW]; tag = "R3"; end
      else if (idx == N_MODE + N_STAT) begin rdata = evt_m; tag = "R4"; end
      else if (idx == N_MODE + N_STAT + 1) begin rdata = DW'(ufl_m); tag = "R9"; end
      if (go && we) begin
        if (isp) oq[p].push_back(wdat);
        else if (idx < N_MODE) mode_m[idx] = wdat;
        else if (idx == N_MODE + N_STAT) clr_e = wdat;
        else if (idx == N_MODE + N_STAT + 1) clr_u = wdat[NPORT-1:0];
      end
      if (go && !we && isp && isz > 0) void'(iq[p].pop_front());
      for (int q = 0; q < NPORT; q++) begin
        if (drain[q]) void'(oq[q].pop_front());
        if (acc[q]) iq[q].push_back(in_data_i[q*DW +: DW]);
      end
      evt_m = (evt_m & ~clr_e) | event_i;
      ufl_m = (ufl_m & ~clr_u) | uset;
      ack_tag = (req && full) ? "R7" : "R5";
      exp_ack = go;
      exp_dat = (go && !we) ? rdata : '0;
      dat_tag = tag;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(64'(wb_ack_o), 64'(exp_ack), ack_tag, "ack");
      chk(64'(wb_dat_o), 64'(exp_dat), dat_tag, "read data");
      for (int i = 0; i < N_MODE; i++)
        chk(64'(mode_o[i*DW +: DW]), 64'(mode_m[i]), "R2", "mode_o");
      for (int q = 0; q < NPORT; q++) begin
        chk(64'(out_valid_o[q]), 64'(oq[q].size() > 0), "R6", "out_valid");
        if (oq[q].size() > 0) chk(64'(out_data_o[q*DW +: DW]), 64'(oq[q][0]), "R6", "out_data");
        chk(64'(in_ready_o[q]), 64'(iq[q].size() < DEPTH), "R8", "in_ready");
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic streams();
    if (rnd) begin
      in_valid_i  = NPORT'($urandom);
      out_ready_i = NPORT'($urandom);
      for (int q = 0; q < NPORT; q++) in_data_i[q*DW +: DW] = $urandom;
      event_i = $urandom & $urandom & $urandom;
      if ($urandom % 8 == 0) status_i = {$urandom, $urandom};
    end
  endtask

  task automatic bus_op(input bit w, input logic [7:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] ev = '0, input int rdy_after = 0);
    int n = 0;
    @(negedge clk);
    streams();
    cyc = 1; stb = 1; we = w; adr = a[7:2]; wdat = d;
    if (ev != '0) event_i = ev;
    forever begin
      @(negedge clk);
      if (ev != '0 && !rnd) event_i = '0;
      streams();
      n++;
      if (rdy_after > 0 && n == rdy_after) out_ready_i = '1;
      if (wb_ack_o) break;
    end
    cyc = 0; stb = 0; we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(64'(wb_ack_o), 0, "R10", "ack in reset");
    chk(64'(mode_o), 0, "R10", "mode in reset");
    chk(64'(out_valid_o), 0, "R10", "out_valid in reset");
    chk(64'(in_ready_o), 64'hF, "R10", "in_ready in reset");
    rst_n = 1;
    // R2 mode registers
    bus_op(1, 8'h00, 32'hA5A5_0F0F);
    bus_op(1, 8'h04, 32'h1234_5678);
    bus_op(0, 8'h00, '0);
    bus_op(0, 8'h04, '0);
    // R3 status: live read, ignored write
    status_i = {32'hCAFE_0002, 32'hBEEF_0001};
    bus_op(0, 8'h08, '0);
    bus_op(1, 8'h08, 32'hFFFF_FFFF);
    bus_op(0, 8'h08, '0);
    status_i[63:32] = 32'h0BAD_F00D;
    bus_op(0, 8'h0C, '0);
    // R4 events: latch, clear, set wins over clear
    @(negedge clk); event_i = 32'h0000_0081;
    @(negedge clk); event_i = '0;
    bus_op(0, 8'h10, '0);
    bus_op(1, 8'h10, 32'h0000_0001);
    bus_op(0, 8'h10, '0);
    bus_op(1, 8'h10, 32'h0000_0080, 32'h0000_0080);
    bus_op(0, 8'h10, '0);
    // R1 unmapped
    bus_op(0, 8'h18, '0);
    bus_op(0, 8'h7C, '0);
    // R6/R7 outbound fill past depth with stalled consumer
    for (int i = 0; i < DEPTH; i++) bus_op(1, 8'h84, 32'h1000 + i);
    bus_op(1, 8'h84, 32'h2000, '0, 5);
    repeat (8) @(negedge clk);
    out_ready_i = '0;
    // R8/R9 inbound fill, drain, underflow
    @(negedge clk); in_valid_i = 4'b0100;
    for (int i = 0; i < 6; i++) begin
      in_data_i[2*DW +: DW] = 32'h3000 + i;
      @(negedge clk);
    end
    in_valid_i = '0;
    for (int i = 0; i < DEPTH + 1; i++) bus_op(0, 8'h88, '0);
    bus_op(0, 8'h14, '0);
    bus_op(1, 8'h14, 32'h4);
    bus_op(0, 8'h14, '0);
    // mixed random traffic
    rnd = 1;
    for (int k = 0; k < 600; k++) begin
      automatic int op = $urandom % 10;
      automatic logic [7:0] a;
      if (op < 4) bus_op(1, 8'h80 | 8'(($urandom % NPORT) << 2), $urandom);
      else if (op < 7) bus_op(0, 8'h80 | 8'(($urandom % NPORT) << 2), '0);
      else begin
        a = 8'(($urandom % 8) << 2);
        bus_op(($urandom % 2) == 1, a, $urandom);
      end
      if ($urandom % 3 == 0) begin @(negedge clk); streams(); end
    end
    rnd = 0;
    in_valid_i = '0; out_ready_i = '1; event_i = '0;
    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule